// File: doc/BRIEF.md
# Two-Pass Dense Classifier

This block is the final dense layer of a small image classifier. It takes a 507-entry feature vector (three flattened 13x13 pooled maps, unsigned 8-bit) and ten rows of signed 8-bit weights, each row with a signed bias. It forms ten class scores with one serial multiply-accumulate unit and reports the index of the largest score as the recognised digit.

The weight memory holds only five rows and their biases at a time, so the layer runs in two halves. When pooling has finished, the block pulses a request to the host, which loads rows 0 to 4. The block waits for the host's "loaded" strobe, computes scores 0 to 4 and pulses a second request. The host then overwrites the memory with rows 5 to 9 and strobes "loaded" again. The block computes scores 5 to 9, picks the winner and pulses a valid strobe with the digit.

Features and weights come from two external synchronous memories. Each memory returns the word at the presented address one clock later. These read ports have a fixed latency and no back-pressure: the block never stalls a read and the memories never refuse one. Control pins are plain level or pulse signals.

Top module: `fc_two_pass_classifier`

## Requirements
- R1: After reset, `wt_req` and `digit_valid` are low, `digit` is 0 and the block is idle.
- R2: A `pool_done` pulse in the idle state causes a single-cycle `wt_req` pulse in the next cycle. A `wt_loaded` strobe seen while idle is ignored: no request and no result follow.
- R3: For local neuron n (0..4) of a half, the block reads feature address i and weight address n*507+i for i = 0..506. It then reads the bias at weight address 2535+n. Weight memory depth is 2540.
- R4: Each score equals the sum of feature(i) * weight(n,i) plus the bias, with features unsigned and weights and bias signed. The sum is held in a 26-bit signed accumulator, which cannot overflow for any input.
- R5: After the fifth score of the first half is stored, `wt_req` pulses for one cycle once more. No second-half result appears until `wt_loaded` is seen. Scores 5..9 then use the reloaded memory at the same addresses as R3.
- R6: `digit` is the index (0..9) of the largest of the ten scores. When scores tie, the lower index wins.
- R7: `digit_valid` is a single-cycle pulse per classification. `digit` changes only in a cycle where `digit_valid` is high, and holds its value until the next result.
- R8: `pool_done` pulses that arrive while a classification is in progress are ignored. They neither add a request nor change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pool_done | input | 1 | Pulse: pooled features are ready, begin a classification |
| wt_req | output | 1 | Pulse: host must load the next half of the weights |
| wt_loaded | input | 1 | Pulse: host has finished loading the requested half |
| feat_addr | output | 9 | Feature memory read address |
| feat_data | input | 8 | Feature word (unsigned), one cycle after its address |
| wt_addr | output | 12 | Weight memory read address |
| wt_data | input | 8 | Weight or bias word (signed), one cycle after its address |
| digit | output | 4 | Recognised digit (index of largest score) |
| digit_valid | output | 1 | Pulse: `digit` carries a new result |

## Verification
The block is tried with fully random features and weights, which checks the signed sums against a bench model. Zero weights with equal biases check the lower-index tie rule, including the case where all ten scores tie. A case where only a second-half bias decides the winner shows that bias addressing and the reload both work for the second half. Saturated inputs, including one where every score is negative, separate true signed accumulation from wrap-around or unsigned comparison. Random host delays before each `wt_loaded`, together with stray `pool_done` and `wt_loaded` strobes, check that the handshake waits for the host and ignores strobes at the wrong time.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MAC,
    ST_DRAIN,
    ST_PICK
  } fc_state_t;
endpackage

// File: rtl/fc_mac.sv
module fc_mac #(
  parameter int XW = 8,
  parameter int WW = 8,
  parameter int AW = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [XW-1:0]        x,
  input  logic signed [WW-1:0] w,
  output logic signed [AW-1:0] total
);
  localparam int PW = XW + WW + 1;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc;

  assign prod  = $signed({1'b0, x}) * w;
  // bias is added on the fly when the last word (the bias) is on w
  assign total = acc + {{(AW-WW){w[WW-1]}}, w};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc + {{(AW-PW){prod[PW-1]}}, prod};
  end
endmodule

// File: rtl/fc_argmax.sv
module fc_argmax #(
  parameter int N  = 10,
  parameter int W  = 26,
  parameter int OW = 4
) (
  input  logic [N-1:0][W-1:0] vals,
  output logic [OW-1:0]       win
);
  logic signed [W-1:0] best;

  always_comb begin
    best = $signed(vals[0]);
    win  = '0;
    for (int k = 1; k < N; k++) begin
      if ($signed(vals[k]) > best) begin   // strict: ties keep lower index
        best = $signed(vals[k]);
        win  = OW'(k);
      end
    end
  end
endmodule

// File: rtl/fc_two_pass_classifier.sv
module fc_two_pass_classifier #(
  parameter int N_IN  = 507,
  parameter int N_OUT = 10,
  parameter int XW    = 8,
  parameter int WW    = 8,
  parameter int AW    = 26
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pool_done,
  output logic                          wt_req,
  input  logic                          wt_loaded,
  output logic [$clog2(N_IN)-1:0]       feat_addr,
  input  logic [XW-1:0]                 feat_data,
  output logic [$clog2((N_OUT/2)*(N_IN+1))-1:0] wt_addr,
  input  logic [WW-1:0]                 wt_data,
  output logic [$clog2(N_OUT)-1:0]      digit,
  output logic                          digit_valid
);
  import fc_pkg::*;

  localparam int HALF   = N_OUT / 2;
  localparam int FA     = $clog2(N_IN);
  localparam int WDEPTH = HALF * (N_IN + 1);
  localparam int WA     = $clog2(WDEPTH);
  localparam int IW     = $clog2(N_IN + 1);
  localparam int NW     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int OW     = $clog2(N_OUT);

  fc_state_t                 state;
  logic                      phase;
  logic [NW-1:0]             nloc;
  logic [IW-1:0]             idx;
  logic                      rd_vld, rd_last;
  logic [N_OUT-1:0][AW-1:0]  score_q;
  logic signed [AW-1:0]      total;
  logic [OW-1:0]             best_idx, slot;
  logic                      at_bias;

  assign at_bias   = (idx == IW'(N_IN));
  assign feat_addr = at_bias ? '0 : FA'(idx);
  assign wt_addr   = at_bias ? WA'(HALF * N_IN) + WA'(nloc)
                             : WA'(nloc) * WA'(N_IN) + WA'(idx);
  assign slot      = phase ? OW'(HALF) + OW'(nloc) : OW'(nloc);

  fc_mac #(.XW(XW), .WW(WW), .AW(AW)) i_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state == ST_DRAIN),
    .en    (rd_vld && !rd_last),
    .x     (feat_data),
    .w     ($signed(wt_data)),
    .total (total)
  );

  fc_argmax #(.N(N_OUT), .W(AW), .OW(OW)) i_argmax (
    .vals (score_q),
    .win  (best_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      phase       <= 1'b0;
      nloc        <= '0;
      idx         <= '0;
      rd_vld      <= 1'b0;
      rd_last     <= 1'b0;
      wt_req      <= 1'b0;
      digit       <= '0;
      digit_valid <= 1'b0;
      score_q     <= '0;
    end else begin
      wt_req      <= 1'b0;
      digit_valid <= 1'b0;
      rd_vld      <= (state == ST_MAC);
      rd_last     <= (state == ST_MAC) && at_bias;
      unique case (state)
        ST_IDLE: if (pool_done) begin
          phase  <= 1'b0;
          nloc   <= '0;
          wt_req <= 1'b1;
          state  <= ST_WAIT;
        end
        ST_WAIT: if (wt_loaded) begin
          idx   <= '0;
          state <= ST_MAC;
        end
        ST_MAC: begin
          if (at_bias) state <= ST_DRAIN;
          else         idx   <= idx + 1'b1;
        end
        ST_DRAIN: begin
          score_q[slot] <= total;
          idx           <= '0;
          if (nloc == NW'(HALF - 1)) begin
            nloc <= '0;
            if (!phase) begin
              phase  <= 1'b1;
              wt_req <= 1'b1;
              state  <= ST_WAIT;
            end else begin
              state <= ST_PICK;
            end
          end else begin
            nloc  <= nloc + 1'b1;
            state <= ST_MAC;
          end
        end
        ST_PICK: begin
          digit       <= best_idx;
          digit_valid <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wt_req |=> !wt_req); // R2
  AST_WT_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wt_addr < WA'(WDEPTH)); // R3
  AST_FEAT_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    feat_addr < FA'(N_IN)); // R3
  AST_NO_RESULT_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    wt_req |=> !digit_valid); // R5
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    digit_valid |-> digit < OW'(N_OUT)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    digit_valid |=> !digit_valid); // R7
  AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(digit) |-> digit_valid); // R7
endmodule

// File: tb/test_fc_two_pass_classifier.sv
`timescale 1ns/1ps
module test_fc_two_pass_classifier;
  localparam int N_IN = 507;
  localparam int N_OUT = 10;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0, pool_done = 1'b0, wt_loaded = 1'b0;
  logic wt_req, digit_valid;
  logic [8:0]  feat_addr;
  logic [11:0] wt_addr;
  logic [7:0]  feat_data, wt_data;
  logic [3:0]  digit;

  logic [7:0]        X [N_IN];
  logic signed [7:0] W [N_OUT][N_IN];
  logic signed [7:0] B [N_OUT];
  int hsel = 0;
  int n_chk = 0, n_bad = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fc_two_pass_classifier i_fc_two_pass_classifier (
    .clk(clk), .rst_n(rst_n), .pool_done(pool_done), .wt_req(wt_req),
    .wt_loaded(wt_loaded), .feat_addr(feat_addr), .feat_data(feat_data),
    .wt_addr(wt_addr), .wt_data(wt_data), .digit(digit), .digit_valid(digit_valid));

  // synchronous memories, one-cycle read latency; hsel models the host reload
  always @(posedge clk) begin
    feat_data <= (int'(feat_addr) < N_IN) ? X[feat_addr] : 8'h00;
    if (int'(wt_addr) < HALF * N_IN)
      wt_data <= W[hsel*HALF + int'(wt_addr) / N_IN][int'(wt_addr) % N_IN];
    else if (int'(wt_addr) < HALF * (N_IN + 1))
      wt_data <= B[hsel*HALF + int'(wt_addr) - HALF*N_IN];
    else
      wt_data <= 8'h00;
  end

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_digit();
    longint best = 0, s;
    int win = 0;
    for (int n = 0; n < N_OUT; n++) begin
      s = longint'(B[n]);
      for (int i = 0; i < N_IN; i++) s += longint'(X[i]) * longint'(W[n][i]);
      if (n == 0 || s > best) begin best = s; win = n; end
    end
    return win;
  endfunction

  task automatic fill(int kind);
    for (int i = 0; i < N_IN; i++) begin
      case (kind)
        0: X[i] = 8'($urandom);
        1: X[i] = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
        default: X[i] = 8'd255;
      endcase
      for (int n = 0; n < N_OUT; n++) W[n][i] = (kind < 2) ? 8'($urandom) : 8'sd0;
    end
    for (int n = 0; n < N_OUT; n++) B[n] = 8'($urandom);
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  // one classification; stray pulses exercise R8
  task automatic run_case(string tag, bit stray);
    int exp_d, reqs, waited;
    exp_d = model_digit();
    hsel = 0;
    pool_done = 1'b1; step(1); pool_done = 1'b0;
    check("R2 first request pulse", wt_req, 1);
    step(1);
    check("R2 request lasts one cycle", wt_req, 0);
    repeat ($urandom % 6) begin step(1); check("R5 no result before load", digit_valid, 0); end
    wt_loaded = 1'b1; step(1); wt_loaded = 1'b0;
    reqs = 0; waited = 0;
    while (reqs == 0 && waited < 4000) begin
      step(1); waited++;
      if (stray && waited == 100) pool_done = 1'b1;
      if (stray && waited == 101) pool_done = 1'b0;
      if (wt_req) reqs++;
      if (digit_valid) check("R5 result before second half", 1, 0);
    end
    check("R5 second request raised", reqs, 1);
    hsel = 1;
    repeat (3 + $urandom % 8) begin
      step(1);
      check("R5 waits for load", digit_valid, 0);
      check("R8/R2 no extra request", wt_req, 0);
    end
    wt_loaded = 1'b1; step(1); wt_loaded = 1'b0;
    waited = 0;
    while (!digit_valid && waited < 4000) begin
      step(1); waited++;
      if (wt_req) check("R8 no extra request", 1, 0);
    end
    check({"R4/R6 digit ", tag}, digit, exp_d);
    step(1);
    check("R7 valid is a pulse", digit_valid, 0);
    step(5);
    check("R7 digit held", digit, exp_d);
  endtask

  initial begin
    void'($urandom(32'd2718));
    step(3);
    check("R1 wt_req after reset", wt_req, 0);
    check("R1 digit_valid after reset", digit_valid, 0);
    check("R1 digit after reset", digit, 0);
    rst_n = 1'b1; step(2);

    // R2: load strobe while idle is ignored
    wt_loaded = 1'b1; step(1); wt_loaded = 1'b0;
    repeat (30) begin
      step(1);
      check("R2 idle ignores wt_loaded req", wt_req, 0);
      check("R2 idle ignores wt_loaded valid", digit_valid, 0);
    end

    fill(0); run_case("random", 0);
    // R6: all scores tie at zero
    fill(0); for (int n = 0; n < N_OUT; n++) begin B[n] = 0; for (int i = 0; i < N_IN; i++) W[n][i] = 0; end
    run_case("all tie", 0);
    // R6: tie between 3 and 7 via bias
    for (int n = 0; n < N_OUT; n++) B[n] = 8'sd10;
    B[3] = 8'sd50; B[7] = 8'sd50;
    run_case("tie 3/7", 0);
    // R3/R5: only a second-half bias decides
    for (int n = 0; n < N_OUT; n++) B[n] = -8'sd5;
    B[9] = 8'sd4;
    run_case("bias 9", 0);
    // R4: extreme magnitudes, positive winner
    fill(2);
    for (int n = 0; n < N_OUT; n++) begin B[n] = 0; for (int i = 0; i < N_IN; i++) W[n][i] = (n == 6) ? 8'sd127 : -8'sd128; end
    run_case("max 6", 0);
    // R4: all scores strongly negative
    for (int n = 0; n < N_OUT; n++) for (int i = 0; i < N_IN; i++) W[n][i] = (n == 2) ? -8'sd127 : -8'sd128;
    run_case("neg 2", 0);
    fill(1); run_case("sparse stray", 1);
    for (int r = 0; r < 3; r++) begin fill(r % 2); run_case("random", r == 1); end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule